// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This unit sits between a 32-bit integer core and a word-wide data memory. Each request carries an opcode, a base register value and a 16-bit immediate. The unit adds the sign-extended immediate to the base to form the effective address, and it decodes the opcode into a direction, an access size and an extension rule.

For stores, the unit copies the byte or halfword onto every lane it could occupy. It then raises only the byte enables that the access covers, so the memory never has to shift data. For loads, the memory answers one cycle after the request. The unit keeps the low address bits and the decoded size from the request cycle, and it picks the right lanes out of the returned word without a register in between. It then sign-extends or zero-extends the result.

A parameter selects the byte order. With little-endian order the lowest address of a word maps to the least significant byte; with big-endian order it maps to the most significant byte. A halfword access on an odd address, or a word access that is not on a 4-byte boundary, raises a misalignment flag. Such an access issues nothing to memory.

Top module: `lsu_lane_unit`

## Requirements
- R1: `mem_addr` equals `req_base` plus `req_imm` sign-extended to 32 bits (a 16-bit immediate of 0xFFFC subtracts 4).
- R2: Opcode 0x28 stores a byte. `mem_wdata` holds the low data byte on all four lanes. `mem_be` has one bit set: for byte offset o = addr[1:0], the bit is o in little-endian order and 3-o in big-endian order. A byte stored and then loaded with 0x24 at the same address returns the same value.
- R3: Opcode 0x29 stores a halfword. `mem_wdata` holds the low 16 data bits twice. `mem_be` is 4'b0011 or 4'b1100 and covers the two lanes that hold addresses addr and addr+1 under the selected byte order.
- R4: Opcode 0x2b stores a word. `mem_be` is 4'b1111, `mem_wdata` equals the data, and `mem_we` is 1.
- R5: Opcode 0x20 loads the addressed byte and sign-extends it. Opcode 0x24 loads the addressed byte and zero-extends it.
- R6: Opcode 0x21 loads the addressed halfword and sign-extends it. Opcode 0x25 loads the addressed halfword and zero-extends it. The byte at the lower address is the low half in little-endian order and the high half in big-endian order.
- R7: Opcode 0x23 returns the full memory word unchanged.
- R8: In big-endian order, after the word 0x00000005 is stored at address 8, a byte load from 8 returns 0 and a byte load from 11 returns 5. In little-endian order the two results are swapped.
- R9: A halfword access with addr[0]=1, or a word access with addr[1:0]≠0, raises `misalign`. In that cycle `mem_req`, `mem_we` and `mem_be` are all 0. A byte access never raises `misalign`.
- R10: A load issued in cycle n sets `ld_valid` in cycle n+1. `ld_data` is built from `mem_rdata` using the offset and size captured in cycle n, even when a different request is issued in cycle n+1.
- R11: An opcode that is not one of the eight listed issues no memory request and never raises `misalign`, and no `ld_valid` follows it.
- R12: During and right after reset `ld_valid` is 0, and with `req_valid` low `mem_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_opcode | input | 6 | Load/store opcode |
| req_base | input | 32 | Base register value |
| req_imm | input | 16 | Signed address offset |
| req_wdata | input | 32 | Register data for stores |
| mem_req | output | 1 | Memory access issued |
| mem_we | output | 1 | Issued access is a write |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_rdata | input | 32 | Memory read word, one cycle after the request |
| ld_valid | output | 1 | Load result present this cycle |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | Current request is misaligned |

## Verification
The store steering path and the load extraction path can be active in the same cycle. In that cycle a new request is being steered from its own offset, while the result of the previous load is extracted from the offset captured one cycle earlier. The bench provokes this by issuing a byte load from offset 3 and, in the very next cycle, a byte store to offset 0. It then checks that the load returns the offset-3 byte of both byte orders and that the store enable mask reflects offset 0. Running a little-endian and a big-endian instance side by side under the same stimulus exposes any lane that is mirrored the wrong way.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  localparam int unsigned XLEN    = 32;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned OP_W    = 6;
  localparam int unsigned LANES   = XLEN / 8;
  localparam int unsigned OFF_W   = $clog2(LANES);

  localparam logic [OP_W-1:0] OP_LDB  = 6'h20;
  localparam logic [OP_W-1:0] OP_LDH  = 6'h21;
  localparam logic [OP_W-1:0] OP_LDW  = 6'h23;
  localparam logic [OP_W-1:0] OP_LDBU = 6'h24;
  localparam logic [OP_W-1:0] OP_LDHU = 6'h25;
  localparam logic [OP_W-1:0] OP_STB  = 6'h28;
  localparam logic [OP_W-1:0] OP_STH  = 6'h29;
  localparam logic [OP_W-1:0] OP_STW  = 6'h2b;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      known;
    logic      is_store;
    acc_size_e size;
    logic      sext;
  } acc_dec_t;

  function automatic logic [XLEN-1:0] f_eff_addr(input logic [XLEN-1:0] base,
                                                 input logic [IMM_W-1:0] imm);
    return base + {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
  endfunction

  function automatic logic f_misaligned(input acc_size_e size,
                                        input logic [OFF_W-1:0] off);
    case (size)
      SZ_HALF: return off[0];
      SZ_WORD: return |off;
      default: return 1'b0;
    endcase
  endfunction

  // physical lane of the byte at offset off within a word
  function automatic logic [OFF_W-1:0] f_byte_lane(input logic [OFF_W-1:0] off,
                                                   input logic big);
    return big ? (OFF_W'(LANES - 1) - off) : off;
  endfunction

  // which 16-bit half of the word holds the halfword starting at off
  function automatic logic f_half_sel(input logic [OFF_W-1:0] off,
                                      input logic big);
    return big ? ~off[OFF_W-1] : off[OFF_W-1];
  endfunction
endpackage

// File: rtl/lsu_decode.sv
module lsu_decode
  import lsu_lane_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output acc_dec_t        dec
);
  always_comb begin
    dec = '{known: 1'b1, is_store: 1'b0, size: SZ_WORD, sext: 1'b0};
    case (opcode)
      OP_LDB:  begin dec.size = SZ_BYTE; dec.sext = 1'b1; end
      OP_LDBU: begin dec.size = SZ_BYTE; end
      OP_LDH:  begin dec.size = SZ_HALF; dec.sext = 1'b1; end
      OP_LDHU: begin dec.size = SZ_HALF; end
      OP_LDW:  begin dec.size = SZ_WORD; end
      OP_STB:  begin dec.size = SZ_BYTE; dec.is_store = 1'b1; end
      OP_STH:  begin dec.size = SZ_HALF; dec.is_store = 1'b1; end
      OP_STW:  begin dec.size = SZ_WORD; dec.is_store = 1'b1; end
      default: dec.known = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_lane_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic             enable,
  input  acc_size_e        size,
  input  logic [OFF_W-1:0] off,
  input  logic [XLEN-1:0]  data,
  output logic [LANES-1:0] be,
  output logic [XLEN-1:0]  wdata
);
  logic [LANES-1:0] mask;

  always_comb begin
    case (size)
      SZ_BYTE: begin
        wdata = {LANES{data[7:0]}};
        mask  = LANES'(1) << f_byte_lane(off, BIG_ENDIAN);
      end
      SZ_HALF: begin
        wdata = {(LANES/2){data[15:0]}};
        mask  = f_half_sel(off, BIG_ENDIAN) ? {2'b11, {(LANES-2){1'b0}}}
                                            : {{(LANES-2){1'b0}}, 2'b11};
      end
      default: begin
        wdata = data;
        mask  = '1;
      end
    endcase
    be = enable ? mask : '0;
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_lane_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic [XLEN-1:0]  rdata,
  input  acc_size_e        size,
  input  logic             sext,
  input  logic [OFF_W-1:0] off,
  output logic [XLEN-1:0]  result
);
  logic [7:0]  byte_v;
  logic [15:0] half_v;

  always_comb begin
    byte_v = rdata[8*f_byte_lane(off, BIG_ENDIAN) +: 8];
    half_v = rdata[16*f_half_sel(off, BIG_ENDIAN) +: 16];
    case (size)
      SZ_BYTE: result = {{(XLEN-8){sext & byte_v[7]}}, byte_v};
      SZ_HALF: result = {{(XLEN-16){sext & half_v[15]}}, half_v};
      default: result = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit
  import lsu_lane_pkg::*;
#(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [5:0]       req_opcode,
  input  logic [31:0]      req_base,
  input  logic [15:0]      req_imm,
  input  logic [31:0]      req_wdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [31:0]      mem_addr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  input  logic [31:0]      mem_rdata,
  output logic             ld_valid,
  output logic [31:0]      ld_data,
  output logic             misalign
);
  acc_dec_t         dec;
  logic [XLEN-1:0]  ea;
  logic [OFF_W-1:0] ea_off;
  logic             op_known;
  logic             bad_align;
  logic             issue;
  logic             issue_load;
  logic             issue_store;

  // load response context captured at issue
  logic             rsp_valid_q;
  acc_size_e        rsp_size_q;
  logic             rsp_sext_q;
  logic [OFF_W-1:0] rsp_off_q;

  lsu_decode u_dec (
    .opcode (req_opcode),
    .dec    (dec)
  );

  assign ea          = f_eff_addr(req_base, req_imm);
  assign ea_off      = ea[OFF_W-1:0];
  assign op_known    = req_valid & dec.known;
  assign bad_align   = f_misaligned(dec.size, ea_off);
  assign issue       = op_known & ~bad_align;
  assign issue_store = issue & dec.is_store;
  assign issue_load  = issue & ~dec.is_store;

  lsu_store_steer #(.BIG_ENDIAN(BIG_ENDIAN)) u_st (
    .enable (issue_store),
    .size   (dec.size),
    .off    (ea_off),
    .data   (req_wdata),
    .be     (mem_be),
    .wdata  (mem_wdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_size_q  <= SZ_WORD;
      rsp_sext_q  <= 1'b0;
      rsp_off_q   <= '0;
    end else begin
      rsp_valid_q <= issue_load;
      if (issue_load) begin
        rsp_size_q <= dec.size;
        rsp_sext_q <= dec.sext;
        rsp_off_q  <= ea_off;
      end
    end
  end

  lsu_load_extract #(.BIG_ENDIAN(BIG_ENDIAN)) u_ld (
    .rdata  (mem_rdata),
    .size   (rsp_size_q),
    .sext   (rsp_sext_q),
    .off    (rsp_off_q),
    .result (ld_data)
  );

  assign mem_req  = issue;
  assign mem_we   = issue_store;
  assign mem_addr = ea;
  assign ld_valid = rsp_valid_q;
  assign misalign = op_known & bad_align;
endmodule

// File: rtl/lsu_lane_chk.sv
module lsu_lane_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       op_known,
  input logic       mem_req,
  input logic       mem_we,
  input logic [3:0] mem_be,
  input logic       misalign,
  input logic       ld_valid
);
  p_we_implies_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_req);

  p_be_only_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |-> mem_be == 4'b0000);

  p_half_lanes_paired_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $countones(mem_be) == 2) |-> (mem_be == 4'b0011 || mem_be == 4'b1100));

  p_be_size_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4));

  p_misalign_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    misalign |-> (!mem_req && !mem_we && mem_be == 4'b0000));

  p_load_returns_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |=> ld_valid);

  p_load_has_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(mem_req && !mem_we));

  p_unknown_silent_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !op_known |-> (!mem_req && !misalign));

  p_idle_no_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> !mem_req);
endmodule

bind lsu_lane_unit lsu_lane_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .op_known  (op_known),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_be    (mem_be),
  .misalign  (misalign),
  .ld_valid  (ld_valid)
);

// File: tb/tb_lsu_lane_unit.sv
`timescale 1ns/1ps
module tb_lsu_lane_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [5:0]  req_opcode = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_imm = '0;
  logic [31:0] req_wdata = '0;

  logic        l_req, l_we, l_ldv, l_mis, b_req, b_we, b_ldv, b_mis;
  logic [31:0] l_addr, l_wd, l_rd, l_ld, b_addr, b_wd, b_rd, b_ld;
  logic [3:0]  l_be, b_be;

  logic [31:0] mem_l [0:15];
  logic [31:0] mem_b [0:15];

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  lsu_lane_unit #(.BIG_ENDIAN(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_base(req_base), .req_imm(req_imm), .req_wdata(req_wdata),
    .mem_req(l_req), .mem_we(l_we), .mem_addr(l_addr), .mem_be(l_be),
    .mem_wdata(l_wd), .mem_rdata(l_rd), .ld_valid(l_ldv), .ld_data(l_ld),
    .misalign(l_mis));

  lsu_lane_unit #(.BIG_ENDIAN(1'b1)) dut_be (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
    .req_base(req_base), .req_imm(req_imm), .req_wdata(req_wdata),
    .mem_req(b_req), .mem_we(b_we), .mem_addr(b_addr), .mem_be(b_be),
    .mem_wdata(b_wd), .mem_rdata(b_rd), .ld_valid(b_ldv), .ld_data(b_ld),
    .misalign(b_mis));

  // word memories with byte enables and one-cycle read
  initial begin
    for (int i = 0; i < 16; i++) begin
      mem_l[i] = '0;
      mem_b[i] = '0;
    end
    l_rd = '0;
    b_rd = '0;
  end

  always @(posedge clk) begin
    if (l_req && l_we) begin
      for (int k = 0; k < 4; k++)
        if (l_be[k]) mem_l[l_addr[5:2]][8*k +: 8] <= l_wd[8*k +: 8];
    end else if (l_req) l_rd <= mem_l[l_addr[5:2]];
    if (b_req && b_we) begin
      for (int k = 0; k < 4; k++)
        if (b_be[k]) mem_b[b_addr[5:2]][8*k +: 8] <= b_wd[8*k +: 8];
    end else if (b_req) b_rd <= mem_b[b_addr[5:2]];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [5:0] op, input logic [31:0] base,
                      input logic [15:0] imm, input logic [31:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_opcode = op; req_base = base; req_imm = imm; req_wdata = wd;
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_opcode = '0;
    #1;
  endtask

  // load result of the previous step, both byte orders
  task automatic chk_ld(input string tag, input logic [31:0] exp_l, input logic [31:0] exp_b);
    chk({tag, " le valid"}, {31'd0, l_ldv}, 32'd1);
    chk({tag, " be valid"}, {31'd0, b_ldv}, 32'd1);
    chk({tag, " le data"}, l_ld, exp_l);
    chk({tag, " be data"}, b_ld, exp_b);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk("R12 ld_valid le", {31'd0, l_ldv}, 32'd0);
    chk("R12 ld_valid be", {31'd0, b_ldv}, 32'd0);
    chk("R12 mem_req idle", {31'd0, l_req | b_req}, 32'd0);
  endtask

  task automatic t_addr();
    step(6'h23, 32'h0000_1000, 16'hFFFC, 0);
    chk("R1 negative imm", l_addr, 32'h0000_0FFC);
    step(6'h23, 32'h0000_1000, 16'h0010, 0);
    chk("R1 positive imm", b_addr, 32'h0000_1010);
    idle();
  endtask

  task automatic t_store_word();
    step(6'h2b, 0, 16'd8, 32'h1122_3344);
    chk("R4 be le", {28'd0, l_be}, 32'hF);
    chk("R4 be be", {28'd0, b_be}, 32'hF);
    chk("R4 wdata", l_wd, 32'h1122_3344);
    chk("R4 we", {31'd0, l_we & b_we}, 32'd1);
    step(6'h23, 0, 16'd8, 0);
    idle();
    chk_ld("R7 word load", 32'h1122_3344, 32'h1122_3344);
  endtask

  task automatic t_store_byte();
    step(6'h28, 0, 16'd5, 32'h1234_56A5);
    chk("R2 be le", {28'd0, l_be}, 32'h2);
    chk("R2 be be", {28'd0, b_be}, 32'h4);
    chk("R2 wdata replicated", b_wd, 32'hA5A5_A5A5);
    step(6'h24, 0, 16'd5, 0);
    idle();
    chk_ld("R2 byte roundtrip", 32'h0000_00A5, 32'h0000_00A5);
  endtask

  task automatic t_store_half();
    step(6'h29, 32'd4, 16'd2, 32'h0000_BEEF);
    chk("R3 be le", {28'd0, l_be}, 32'hC);
    chk("R3 be be", {28'd0, b_be}, 32'h3);
    chk("R3 wdata replicated", l_wd, 32'hBEEF_BEEF);
    step(6'h25, 0, 16'd6, 0);
    step(6'h21, 0, 16'd6, 0);
    chk_ld("R6 lhu roundtrip", 32'h0000_BEEF, 32'h0000_BEEF);
    idle();
    chk_ld("R6 lh roundtrip", 32'hFFFF_BEEF, 32'hFFFF_BEEF);
  endtask

  task automatic t_extend();
    step(6'h2b, 0, 16'd12, 32'h80FF_7F01);
    step(6'h20, 0, 16'd13, 0);
    step(6'h24, 0, 16'd13, 0);
    chk_ld("R5 lb 13", 32'h0000_007F, 32'hFFFF_FFFF);
    step(6'h20, 0, 16'd15, 0);
    chk_ld("R5 lbu 13", 32'h0000_007F, 32'h0000_00FF);
    step(6'h21, 0, 16'd12, 0);
    chk_ld("R5 lb 15", 32'hFFFF_FF80, 32'h0000_0001);
    step(6'h21, 0, 16'd14, 0);
    chk_ld("R6 lh 12", 32'h0000_7F01, 32'hFFFF_80FF);
    step(6'h25, 0, 16'd14, 0);
    chk_ld("R6 lh 14", 32'hFFFF_80FF, 32'h0000_7F01);
    idle();
    chk_ld("R6 lhu 14", 32'h0000_80FF, 32'h0000_7F01);
  endtask

  task automatic t_endian();
    step(6'h2b, 0, 16'd8, 32'h0000_0005);
    step(6'h20, 0, 16'd8, 0);
    step(6'h20, 0, 16'd11, 0);
    chk_ld("R8 byte at 8", 32'h0000_0005, 32'h0000_0000);
    idle();
    chk_ld("R8 byte at 11", 32'h0000_0000, 32'h0000_0005);
  endtask

  task automatic t_misalign();
    step(6'h29, 0, 16'd1, 32'hFFFF_FFFF);
    chk("R9 half odd flag", {31'd0, l_mis & b_mis}, 32'd1);
    chk("R9 half odd no write", {26'd0, l_req, l_we, l_be}, 32'd0);
    step(6'h23, 0, 16'd6, 0);
    chk("R9 word flag", {31'd0, b_mis}, 32'd1);
    chk("R9 word no req", {31'd0, b_req}, 32'd0);
    step(6'h28, 0, 16'd3, 32'h0000_0000);
    chk("R9 no load after misaligned", {31'd0, l_ldv | b_ldv}, 32'd0);
    chk("R9 byte never flagged", {31'd0, l_mis | b_mis}, 32'd0);
    idle();
  endtask

  task automatic t_overlap();
    step(6'h20, 0, 16'd15, 0);
    step(6'h28, 0, 16'd16, 32'h0000_0077);
    chk_ld("R10 load during store", 32'hFFFF_FF80, 32'h0000_0001);
    chk("R10 store be le same cycle", {28'd0, l_be}, 32'h1);
    chk("R10 store be be same cycle", {28'd0, b_be}, 32'h8);
    idle();
  endtask

  task automatic t_unknown();
    step(6'h22, 0, 16'd1, 0);
    chk("R11 no req", {31'd0, l_req | b_req}, 32'd0);
    chk("R11 no flag", {31'd0, l_mis | b_mis}, 32'd0);
    idle();
    chk("R11 no load", {31'd0, l_ldv | b_ldv}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R12 ld_valid in reset", {31'd0, l_ldv | b_ldv}, 32'd0);
    rst_n = 1'b1;
    t_reset();
    t_addr();
    t_store_word();
    t_store_byte();
    t_store_half();
    t_extend();
    t_endian();
    t_misalign();
    t_overlap();
    t_unknown();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule